// File: doc/BRIEF.md
# Tag-Synchronized Four-Lane Down Mixer

The block takes one stream of signed 14-bit ADC samples and multiplies every sample by the cosine and the sine of four separate numerically controlled oscillators. Each accepted sample produces one output beat that carries four I/Q pairs. The I/Q pairs are delivered in parallel, one pair per oscillator. Each oscillator has a 32-bit phase accumulator. The accumulator advances once per accepted sample by that lane's active tuning word. The top ten phase bits drive a quarter-wave sine table.

A tag input marks reference events, and every tag clears all four phase accumulators. Tuning words are written through a simple write port into a staging bank. They reach the oscillators only on a double-tag, which is two tags no more than a programmable number of clock cycles apart. All four lanes therefore switch frequency on the same edge, and the harmonic can be changed while the block runs with no relative phase slip between lanes. A channel enable forces all results to zero.

Both sample interfaces are valid/ready. A beat on the input moves when `s_valid` and `s_ready` are both high. A beat on the output moves when `m_valid` and `m_ready` are both high. There is one output register. `s_ready` is high whenever that register is empty or is being drained in the same cycle. While the consumer holds `m_ready` low, the pending result stays unchanged and no new sample is taken. Both rules are stated in R10.

Top module: `tag_lo_mixer`

## Requirements
- R1: Each lane k (0..3) has its own phase accumulator. An accepted sample is mixed using the accumulator value held before that edge. On that edge the accumulator adds lane k's active tuning word, modulo 2^32.
- R2: The ten most significant phase bits p select the trig values. Bits p[9:8] select the quadrant and p[7:0] index a table T[n] = round(32767*sin((n+0.5)*pi/512)), n = 0..255. The sine is T[idx] for quadrant 0, T[255-idx] for quadrant 1, -T[idx] for quadrant 2 and -T[255-idx] for quadrant 3. The cosine is the sine of p+256, taken modulo 1024.
- R3: I = (x*cos + 2048) >>> 12 and Q = (x*sin + 2048) >>> 12, where x is the sample and >>> is an arithmetic shift. Each result is an 18-bit two's-complement value. Lane k occupies bits [18k+17:18k] of `m_i` and `m_q`.
- R4: A tag clears all four accumulators on the next edge. A sample accepted in the same cycle as the tag still uses the phase held before the clear.
- R5: A write with `wr_addr` = k, for k from 0 to 3, stores `wr_data` as lane k's staged tuning word. Staging alone never changes the active word that the lane uses.
- R6: A tag arriving d cycles after an arming tag, with 1 <= d <= window, is a double-tag. It copies all four staged words into the active words on one edge. A double-tag leaves the detector unarmed, so the next tag only arms it again. A lone tag, or a second tag with d > window, changes no active word.
- R7: A staging write in the same cycle as a double-tag, or in any later cycle, takes effect only at the next double-tag.
- R8: A write with `wr_addr` = 4 sets the window to `wr_data[15:0]` from the next cycle onwards. The window resets to 8. Writes to addresses 5 to 7 are ignored.
- R9: A sample accepted while `ch_enable` is low produces zero on all eight I and Q outputs.
- R10: `s_ready` = !`m_valid` || `m_ready`. Each accepted sample yields exactly one output beat, valid from the next cycle. While `m_valid` is high and `m_ready` is low, `m_i` and `m_q` do not change.
- R11: After reset, `m_valid` is low, `s_ready` is high, and all staged and active words and all accumulators are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_enable | input | 1 | Channel enable; low forces zero results |
| tag | input | 1 | Reference event pulse |
| wr_en | input | 1 | Parameter write strobe |
| wr_addr | input | 3 | 0-3 staged tuning word of a lane, 4 double-tag window |
| wr_data | input | 32 | Write data |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Input sample accepted when high with s_valid |
| s_data | input | 14 | Signed ADC sample |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Consumer accepts output beat |
| m_i | output | 72 | Four packed 18-bit in-phase results |
| m_q | output | 72 | Four packed 18-bit quadrature results |

## Verification
The assertions check four rules on every cycle. A held output beat stays stable and an accepted sample always produces a beat. Accumulators clear after a tag, and the active words change only on a double-tag, which leaves the detector unarmed. A disabled channel yields zeros. The exact trig values and the rounding can only be shown by the bench's reference model, which compares every beat. The same holds for which tag pairs count as double-tags under a changed window, and for when a staged word finally reaches its lane. The bench drives scenarios with random stalls, lone tags, pairs inside and outside the window, and writes that coincide with a double-tag.

// File: rtl/lo_mix_pkg.sv
package lo_mix_pkg;
  localparam int REG_AW   = 3;
  localparam int WIN_ADDR = 4;
  localparam real PI_R    = 3.14159265358979323846;
endpackage

// File: rtl/lo_trig_rom.sv
module lo_trig_rom #(
  parameter int TBL_AW = 8,
  parameter int AMP_W  = 16
) (
  input  logic [TBL_AW+1:0]        phase,
  output logic signed [AMP_W-1:0]  sin_o,
  output logic signed [AMP_W-1:0]  cos_o
);
  localparam int  DEPTH = 1 << TBL_AW;
  localparam real AMPL  = real'((1 << (AMP_W - 1)) - 1);

  logic [AMP_W-1:0] tbl [DEPTH];

  for (genvar n = 0; n < DEPTH; n++) begin : g_tbl
    localparam real ANG = (real'(n) + 0.5) * lo_mix_pkg::PI_R / (2.0 * real'(DEPTH));
    assign tbl[n] = AMP_W'($rtoi(AMPL * $sin(ANG) + 0.5));
  end

  logic [TBL_AW+1:0] cph;
  logic [TBL_AW-1:0] s_ix, c_ix;
  logic signed [AMP_W-1:0] s_mag, c_mag;

  always_comb begin
    cph   = phase + (TBL_AW+2)'(DEPTH);
    s_ix  = phase[TBL_AW] ? ~phase[TBL_AW-1:0] : phase[TBL_AW-1:0];
    c_ix  = cph[TBL_AW]   ? ~cph[TBL_AW-1:0]   : cph[TBL_AW-1:0];
    s_mag = $signed(tbl[s_ix]);
    c_mag = $signed(tbl[c_ix]);
    sin_o = phase[TBL_AW+1] ? -s_mag : s_mag;
    cos_o = cph[TBL_AW+1]   ? -c_mag : c_mag;
  end
endmodule

// File: rtl/lo_tag_seq.sv
module lo_tag_seq #(
  parameter int N_LO    = 4,
  parameter int PHASE_W = 32,
  parameter int GAP_W   = 16,
  parameter int WIN_RST = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              tag,
  input  logic                              wr_en,
  input  logic [lo_mix_pkg::REG_AW-1:0]     wr_addr,
  input  logic [PHASE_W-1:0]                wr_data,
  output logic [N_LO-1:0][PHASE_W-1:0]      active_o
);
  logic [N_LO-1:0][PHASE_W-1:0] staged;
  logic [GAP_W-1:0] window, gap;
  logic armed, dbl;

  assign dbl = tag && armed && (gap <= window);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      window <= GAP_W'(WIN_RST);
      gap    <= '0;
      armed  <= 1'b0;
    end else begin
      if (wr_en && wr_addr == lo_mix_pkg::REG_AW'(lo_mix_pkg::WIN_ADDR))
        window <= wr_data[GAP_W-1:0];
      if (dbl) begin
        armed <= 1'b0;
      end else if (tag) begin
        armed <= 1'b1;
        gap   <= GAP_W'(1);
      end else if (armed) begin
        if (gap >= window) armed <= 1'b0;
        else               gap   <= gap + GAP_W'(1);
      end
    end
  end

  for (genvar k = 0; k < N_LO; k++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        staged[k]   <= '0;
        active_o[k] <= '0;
      end else begin
        if (dbl) active_o[k] <= staged[k];
        if (wr_en && wr_addr == lo_mix_pkg::REG_AW'(k)) staged[k] <= wr_data;
      end
    end
  end

  AST_ACTIVE_ONLY_ON_DBL: assert property (@(posedge clk) disable iff (!rst_n)
    !dbl |=> $stable(active_o)); // R5
  AST_DBL_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    dbl |=> !armed); // R6
endmodule

// File: rtl/lo_mix_lane.sv
module lo_mix_lane #(
  parameter int DATA_W  = 14,
  parameter int PHASE_W = 32,
  parameter int TBL_AW  = 8,
  parameter int AMP_W   = 16,
  parameter int OUT_W   = 18
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tag,
  input  logic                      accept,
  input  logic                      enable,
  input  logic [PHASE_W-1:0]        ftw,
  input  logic signed [DATA_W-1:0]  sample,
  output logic [OUT_W-1:0]          i_o,
  output logic [OUT_W-1:0]          q_o
);
  localparam int PROD_W = DATA_W + AMP_W;
  localparam int SHIFT  = PROD_W - OUT_W;

  logic [PHASE_W-1:0] acc;
  logic signed [AMP_W-1:0] sin_v, cos_v;
  logic signed [PROD_W:0] pi_w, pq_w;

  lo_trig_rom #(.TBL_AW(TBL_AW), .AMP_W(AMP_W)) u_rom (
    .phase (acc[PHASE_W-1 -: TBL_AW+2]),
    .sin_o (sin_v),
    .cos_o (cos_v)
  );

  always_comb begin
    pi_w = (PROD_W+1)'(sample * cos_v) + (PROD_W+1)'(1 << (SHIFT - 1));
    pq_w = (PROD_W+1)'(sample * sin_v) + (PROD_W+1)'(1 << (SHIFT - 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0;
      i_o <= '0;
      q_o <= '0;
    end else begin
      if (tag)         acc <= '0;
      else if (accept) acc <= acc + ftw;
      if (accept) begin
        i_o <= enable ? pi_w[SHIFT +: OUT_W] : '0;
        q_o <= enable ? pq_w[SHIFT +: OUT_W] : '0;
      end
    end
  end

  AST_PHASE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    tag |=> acc == '0); // R4
endmodule

// File: rtl/tag_lo_mixer.sv
module tag_lo_mixer #(
  parameter int N_LO    = 4,
  parameter int DATA_W  = 14,
  parameter int PHASE_W = 32,
  parameter int TBL_AW  = 8,
  parameter int AMP_W   = 16,
  parameter int OUT_W   = 18,
  parameter int GAP_W   = 16,
  parameter int WIN_RST = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ch_enable,
  input  logic                          tag,
  input  logic                          wr_en,
  input  logic [lo_mix_pkg::REG_AW-1:0] wr_addr,
  input  logic [PHASE_W-1:0]            wr_data,
  input  logic                          s_valid,
  output logic                          s_ready,
  input  logic [DATA_W-1:0]             s_data,
  output logic                          m_valid,
  input  logic                          m_ready,
  output logic [N_LO*OUT_W-1:0]         m_i,
  output logic [N_LO*OUT_W-1:0]         m_q
);
  logic accept;
  logic [N_LO-1:0][PHASE_W-1:0] active;

  assign s_ready = !m_valid || m_ready;
  assign accept  = s_valid && s_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)       m_valid <= 1'b0;
    else if (accept)  m_valid <= 1'b1;
    else if (m_ready) m_valid <= 1'b0;
  end

  lo_tag_seq #(.N_LO(N_LO), .PHASE_W(PHASE_W), .GAP_W(GAP_W), .WIN_RST(WIN_RST)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .tag      (tag),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .active_o (active)
  );

  for (genvar k = 0; k < N_LO; k++) begin : g_lane
    lo_mix_lane #(.DATA_W(DATA_W), .PHASE_W(PHASE_W), .TBL_AW(TBL_AW),
                  .AMP_W(AMP_W), .OUT_W(OUT_W)) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .tag    (tag),
      .accept (accept),
      .enable (ch_enable),
      .ftw    (active[k]),
      .sample ($signed(s_data)),
      .i_o    (m_i[k*OUT_W +: OUT_W]),
      .q_o    (m_q[k*OUT_W +: OUT_W])
    );
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_i) && $stable(m_q)); // R10
  AST_BEAT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> m_valid); // R10
  AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !ch_enable |=> m_i == '0 && m_q == '0); // R9
endmodule

// File: tb/tag_lo_mixer_test.sv
`timescale 1ns/1ps
module tag_lo_mixer_test;
  logic clk = 0, rst_n = 0, ch_enable = 1, tag = 0, wr_en = 0;
  logic [2:0] wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic s_valid = 0, m_ready = 1;
  logic [13:0] s_data = 0;
  wire s_ready, m_valid;
  wire [71:0] m_i, m_q;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  string cur_req = "R11";

  always #2.5 clk = ~clk;

  tag_lo_mixer uut (
    .clk(clk), .rst_n(rst_n), .ch_enable(ch_enable), .tag(tag),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_i(m_i), .m_q(m_q)
  );

  // Reference model
  int tbl [256];
  bit [31:0] r_stg [4], r_act [4], r_acc [4];
  int r_win;
  bit r_armed;
  longint r_last, r_t;
  bit ev;
  int ei [4], eq [4];

  function automatic int trig_sin(bit [9:0] p);
    int m;
    m = p[8] ? tbl[255 - p[7:0]] : tbl[p[7:0]];
    return p[9] ? -m : m;
  endfunction

  initial begin
    for (int n = 0; n < 256; n++)
      tbl[n] = $rtoi(32767.0 * $sin((real'(n) + 0.5) * 3.14159265358979323846 / 512.0) + 0.5);
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) begin
        r_stg[k] = 0; r_act[k] = 0; r_acc[k] = 0; ei[k] = 0; eq[k] = 0;
      end
      r_win = 8; r_armed = 0; r_last = 0; r_t = 0; ev = 0;
    end else begin
      bit acc_ok, is_dbl;
      int x;
      acc_ok = s_valid && (!ev || m_ready);
      x = $signed(s_data);
      if (acc_ok) begin
        for (int k = 0; k < 4; k++) begin
          bit [9:0] ph;
          ph = r_acc[k][31:22];
          ei[k] = ch_enable ? ((x * trig_sin(ph + 10'd256) + 2048) >>> 12) : 0;
          eq[k] = ch_enable ? ((x * trig_sin(ph) + 2048) >>> 12) : 0;
        end
        ev = 1;
      end else if (m_ready) ev = 0;
      is_dbl = tag && r_armed && (r_t - r_last) <= r_win;
      for (int k = 0; k < 4; k++) begin
        if (tag) r_acc[k] = 0;
        else if (acc_ok) r_acc[k] = r_acc[k] + r_act[k];
        if (is_dbl) r_act[k] = r_stg[k];
        if (wr_en && wr_addr == k) r_stg[k] = wr_data;
      end
      if (is_dbl) r_armed = 0;
      else if (tag) begin r_armed = 1; r_last = r_t; end
      if (wr_en && wr_addr == 4) r_win = wr_data[15:0];
      r_t++;
    end
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    if (rst_n) begin
      check(m_valid == ev, "R10", "m_valid", m_valid, ev);
      check(s_ready == (!ev || m_ready), "R10", "s_ready", s_ready, !ev || m_ready);
      if (ev && m_valid)
        for (int k = 0; k < 4; k++) begin
          check(int'($signed(m_i[k*18 +: 18])) == ei[k], {cur_req, " R1 R2 R3"},
                $sformatf("I lane %0d", k), $signed(m_i[k*18 +: 18]), ei[k]);
          check(int'($signed(m_q[k*18 +: 18])) == eq[k], {cur_req, " R1 R2 R3"},
                $sformatf("Q lane %0d", k), $signed(m_q[k*18 +: 18]), eq[k]);
        end
    end
  endtask

  task automatic idle();
    s_valid = 0; tag = 0; wr_en = 0;
  endtask

  task automatic wr(int a, bit [31:0] d);
    wr_en = 1; wr_addr = 3'(a); wr_data = d; tick(); wr_en = 0;
  endtask

  task automatic pulse_tag();
    tag = 1; tick(); tag = 0;
  endtask

  task automatic stream(int n, int p_valid, int p_ready);
    for (int c = 0; c < n; c++) begin
      s_valid = ($urandom % 100) < p_valid;
      s_data  = 14'($urandom);
      m_ready = ($urandom % 100) < p_ready;
      tick();
    end
    s_valid = 0; m_ready = 1;
  endtask

  task automatic gap(int n);
    for (int c = 0; c < n; c++) tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check(m_valid == 0, "R11", "m_valid after reset", m_valid, 0);
    check(s_ready == 1, "R11", "s_ready after reset", s_ready, 1);
    check(m_i == 0 && m_q == 0, "R11", "outputs after reset", m_i[17:0], 0);
    rst_n = 1;
    tick();

    cur_req = "R5";
    wr(0, 32'h0100_0000); wr(1, 32'h0234_5678); wr(2, 32'h1000_0000); wr(3, 32'hF000_0001);
    stream(200, 80, 70);

    cur_req = "R6";
    pulse_tag(); gap(40);
    stream(100, 90, 90);
    pulse_tag(); gap(9); pulse_tag();  // spacing 10 > window 8
    stream(100, 90, 60);

    pulse_tag(); gap(2); pulse_tag();  // spacing 3: double-tag
    stream(300, 85, 60);
    pulse_tag(); gap(1); pulse_tag(); gap(1); pulse_tag(); // third tag only arms
    stream(150, 100, 100);

    cur_req = "R7";
    wr(0, 32'h0333_3333);
    pulse_tag(); gap(2);
    tag = 1; wr_en = 1; wr_addr = 1; wr_data = 32'h0777_0000; tick(); wr_en = 0; tag = 0;
    stream(150, 90, 80);
    wr(2, 32'h0055_5555);
    stream(80, 90, 80);
    pulse_tag(); tick(); pulse_tag();
    stream(150, 90, 80);

    cur_req = "R8";
    wr(4, 32'h0000_0014); wr(5, 32'hFFFF_FFFF); wr(3, 32'h2222_2222);
    gap(30);
    pulse_tag(); gap(14); pulse_tag();  // spacing 15 <= 20
    stream(150, 90, 80);
    wr(4, 32'h0000_0000); gap(5);
    wr(0, 32'h0999_9999);
    pulse_tag(); pulse_tag();           // spacing 1 > window 0
    stream(100, 90, 80);

    cur_req = "R9";
    ch_enable = 0;
    stream(100, 90, 70);
    s_valid = 1; s_data = 14'h1FFF; tick(); s_valid = 0;
    check(m_i == 0 && m_q == 0, "R9", "disabled outputs", m_i[17:0], 0);
    ch_enable = 1;

    cur_req = "R4";
    wr(4, 32'h0000_0008);
    for (int r = 0; r < 12; r++) begin
      stream(37, 95, 75);
      s_valid = 1; s_data = 14'($urandom); tag = 1; tick(); tag = 0; s_valid = 0;
    end

    cur_req = "R10";
    s_valid = 1; s_data = 14'h0ABC; m_ready = 0; tick();
    s_valid = 0;
    begin
      logic [71:0] hold_i;
      hold_i = m_i;
      gap(4);
      check(m_valid == 1 && m_i == hold_i, "R10", "held beat", m_i[17:0], hold_i[17:0]);
    end
    m_ready = 1; tick();
    stream(400, 70, 40);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule